// File: doc/BRIEF.md
# Factorized Periodic Pulse Generator

The block emits a pulse one clock cycle wide each time a fixed number of count-enable assertions have been seen. The number is the parameter `PERIOD`, fixed at elaboration and not changeable while running. Cycles with the enable low do not advance the count.

A single wide binary counter is not used. The period is split at elaboration time into stages. Within a stage, every prime `p` that divides the remaining period gives one factor: the largest power of `p` that divides the period and does not exceed `MAX_RING`. Factors built this way are pairwise coprime. Each factor becomes a rotating one-hot ring, and the ring taps are ANDed. The combined stage pulse then acts as the count enable of the next stage, which covers what is left of the period.

When nothing that is left can be split into an allowed ring, the chain ends in a terminal stage:
- a single long ring, if the leftover is at most `LONG_RING_MAX`;
- otherwise a plain modulo counter.

A typical use is to divide a strobe down to a slow periodic tick for timers, refresh or sampling.

Top module: `periodic_pulse_gen`

## Requirements
- R1: After reset, the first pulse occurs on exactly the `PERIOD`-th cycle in which `count_en` is high, and never earlier.
- R2: `pulse` is asserted only in a cycle where `count_en` is high, and it is combinational from `count_en` in that cycle.
- R3: After the first pulse, the next pulse comes once every `PERIOD` enabled cycles. For `PERIOD` > 1, no two pulses are in consecutive cycles.
- R4: Cycles with `count_en` low, in any number, change neither the position in the period nor any ring state.
- R5: Each ring of length L holds exactly one set bit. After reset that bit is placed so that it reaches the output position on the L-th enable.
- R6: The ring lengths within a stage are pairwise coprime, none exceeds `MAX_RING`, and their product is the stage period. For example, `PERIOD` = 30 builds rings of 2, 3 and 5.
- R7: With `PERIOD` = 1, `pulse` equals `count_en` in every cycle.
- R8: A leftover prime larger than `MAX_RING` becomes a modulo counter stage. For example, 510 with `MAX_RING` = 16 is built as rings 2, 3 and 5 feeding a counter of 17.
- R9: A terminal leftover of at most `LONG_RING_MAX` becomes a single long ring. For example, 323 = 17·19 with `MAX_RING` = 16 and `LONG_RING_MAX` = 400 becomes one ring of 323.
- R10: A synchronous active-high `rst` held for at least one clock edge restarts the period from zero, including in the middle of a period.
- R11: A factor above `MAX_RING` that is a prime power is split across cascaded stages. For example, 64 with `MAX_RING` = 16 becomes a ring of 16 feeding a ring of 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| count_en | input | 1 | One enable assertion per cycle in which it is high |
| pulse | output | 1 | Single-cycle pulse on every `PERIOD`-th enable |

## Verification
Two events can coincide in one cycle:
- the moment when every ring of a stage sits on its tap together, which produces the stage's carry;
- the step of the downstream stage that completes its own count.

The overall pulse exists only when both happen on the same enable. Random enable patterns with gaps are run through several whole periods of five configurations (terminal counter, terminal long ring, cascade of two rings, pure rings, period 1). This makes those coincidences happen after differing histories of idle cycles. Each cycle's output is judged against a modulo-`PERIOD` enable count kept by the bench, and a reset in the middle of a period checks that the coincidence is restarted cleanly.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

    localparam int MAX_STAGES = 32;

    typedef enum logic [1:0] {
        STG_RINGS   = 2'd0,
        STG_LONG    = 2'd1,
        STG_COUNTER = 2'd2
    } stage_kind_e;

    function automatic bit is_prime(int n);
        if (n < 2) return 1'b0;
        for (int d = 2; d * d <= n; d++) begin
            if (n % d == 0) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic int gcd(int a, int b);
        int x;
        int y;
        int t;
        x = a;
        y = b;
        while (y != 0) begin
            t = x % y;
            x = y;
            y = t;
        end
        return x;
    endfunction

    // Length of the idx-th ring of a stage whose remaining period is n.
    // Zero when the stage has fewer rings than idx+1.
    function automatic int ring_len(int n, int lmax, int idx);
        int seen;
        int q;
        seen = 0;
        for (int p = 2; p <= lmax; p++) begin
            if (is_prime(p) && (n % p == 0)) begin
                q = 1;
                while ((q * p <= lmax) && (n % (q * p) == 0)) q = q * p;
                if (seen == idx) return q;
                seen++;
            end
        end
        return 0;
    endfunction

    function automatic int ring_count(int n, int lmax);
        int c;
        c = 0;
        for (int p = 2; p <= lmax; p++) begin
            if (is_prime(p) && (n % p == 0)) c++;
        end
        return c;
    endfunction

    function automatic int ring_product(int n, int lmax);
        int prod;
        prod = 1;
        for (int i = 0; i < ring_count(n, lmax); i++) begin
            prod = prod * ring_len(n, lmax, i);
        end
        return prod;
    endfunction

    // Period still to be covered at the input of stage s.
    function automatic int stage_span(int period, int lmax, int s);
        int n;
        int pr;
        n = period;
        for (int i = 0; i < s; i++) begin
            pr = ring_product(n, lmax);
            if (pr == 1) n = 1;
            else n = n / pr;
        end
        return n;
    endfunction

    function automatic int stage_count(int period, int lmax);
        int c;
        c = 0;
        for (int s = 0; s < MAX_STAGES; s++) begin
            if (stage_span(period, lmax, s) > 1) c = s + 1;
        end
        return c;
    endfunction

    function automatic stage_kind_e stage_kind(int n, int lmax, int longmax);
        if (ring_product(n, lmax) > 1) return STG_RINGS;
        if (n <= longmax) return STG_LONG;
        return STG_COUNTER;
    endfunction

endpackage

// File: rtl/ppg_ring.sv
module ppg_ring #(
    parameter int LEN = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    output logic tap
);
    localparam logic [LEN-1:0] SEED = {1'b1, {(LEN-1){1'b0}}} >> 0;

    logic [LEN-1:0] ring_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ring_q <= SEED;
        end else if (adv) begin
            ring_q <= (ring_q >> 1) | (ring_q << (LEN - 1));
        end
    end

    assign tap = ring_q[0];

    // R5
    ring_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot(ring_q));

    // R4
    ring_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(ring_q));

endmodule

// File: rtl/ppg_counter.sv
module ppg_counter #(
    parameter int N = 17
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    output logic tap
);
    localparam int W = (N > 2) ? $clog2(N) : 1;
    localparam logic [W-1:0] LAST = W'(N - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign tap = (cnt_q == LAST);

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    // R4
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(cnt_q));

endmodule

// File: rtl/ppg_stage.sv
module ppg_stage
    import ppg_pkg::*;
#(
    parameter int SPAN     = 2,
    parameter int MAX_RING = 16,
    parameter int LONG_MAX = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic en_in,
    output logic fire_out
);
    localparam stage_kind_e KIND   = stage_kind(SPAN, MAX_RING, LONG_MAX);
    localparam int          NRINGS = ring_count(SPAN, MAX_RING);

    generate
        if (KIND == STG_RINGS) begin : g_rings
            logic [NRINGS-1:0] taps;
            for (genvar r = 0; r < NRINGS; r++) begin : g_ring
                ppg_ring #(.LEN(ring_len(SPAN, MAX_RING, r))) ring_u (
                    .clk (clk),
                    .rst (rst),
                    .adv (en_in),
                    .tap (taps[r])
                );
            end
            assign fire_out = en_in & (&taps);

            // R6
            initial begin
                for (int a = 0; a < NRINGS; a++) begin
                    coprime_rings_chk: assert (ring_len(SPAN, MAX_RING, a) <= MAX_RING);
                    for (int b = a + 1; b < NRINGS; b++) begin
                        pair_gcd_chk: assert (gcd(ring_len(SPAN, MAX_RING, a),
                                                  ring_len(SPAN, MAX_RING, b)) == 1);
                    end
                end
            end
        end else if (KIND == STG_LONG) begin : g_long
            logic tap;
            ppg_ring #(.LEN(SPAN)) long_u (
                .clk (clk),
                .rst (rst),
                .adv (en_in),
                .tap (tap)
            );
            assign fire_out = en_in & tap;
        end else begin : g_count
            logic tap;
            ppg_counter #(.N(SPAN)) cnt_u (
                .clk (clk),
                .rst (rst),
                .adv (en_in),
                .tap (tap)
            );
            assign fire_out = en_in & tap;
        end
    endgenerate

    // R2
    stage_fire_en_chk: assert property (@(posedge clk) disable iff (rst)
        fire_out |-> en_in);

endmodule

// File: rtl/periodic_pulse_gen.sv
module periodic_pulse_gen
    import ppg_pkg::*;
#(
    parameter int PERIOD        = 510,
    parameter int MAX_RING      = 16,
    parameter int LONG_RING_MAX = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic count_en,
    output logic pulse
);
    localparam int NST = stage_count(PERIOD, MAX_RING);

    logic [NST:0] chain;

    assign chain[0] = count_en;

    generate
        for (genvar s = 0; s < NST; s++) begin : g_stage
            ppg_stage #(
                .SPAN     (stage_span(PERIOD, MAX_RING, s)),
                .MAX_RING (MAX_RING),
                .LONG_MAX (LONG_RING_MAX)
            ) stage_u (
                .clk      (clk),
                .rst      (rst),
                .en_in    (chain[s]),
                .fire_out (chain[s+1])
            );
        end
    endgenerate

    assign pulse = chain[NST];

    // R6
    initial begin
        period_valid_chk: assert (PERIOD >= 1 && MAX_RING >= 2);
        chain_closed_chk: assert (stage_span(PERIOD, MAX_RING, NST) == 1);
    end

    // R2
    pulse_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        pulse |-> count_en);

    generate
        if (PERIOD > 1) begin : g_width
            // R3
            single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
                pulse |=> !pulse);
        end
    endgenerate

endmodule

// File: tb/periodic_pulse_gen_tb_top.sv
module periodic_pulse_gen_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic count_en = 1'b0;
    logic p_a, p_b, p_c, p_d, p_e;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    // R8: rings 2,3,5 then counter 17
    periodic_pulse_gen #(.PERIOD(510), .MAX_RING(16), .LONG_RING_MAX(0)) dut_i (
        .clk(clk), .rst(rst), .count_en(count_en), .pulse(p_a));
    // R6: rings 2,3,5
    periodic_pulse_gen #(.PERIOD(30), .MAX_RING(16), .LONG_RING_MAX(0)) dut_b (
        .clk(clk), .rst(rst), .count_en(count_en), .pulse(p_b));
    // R7
    periodic_pulse_gen #(.PERIOD(1), .MAX_RING(16), .LONG_RING_MAX(0)) dut_c (
        .clk(clk), .rst(rst), .count_en(count_en), .pulse(p_c));
    // R9, R5: one long ring of 323
    periodic_pulse_gen #(.PERIOD(323), .MAX_RING(16), .LONG_RING_MAX(400)) dut_d (
        .clk(clk), .rst(rst), .count_en(count_en), .pulse(p_d));
    // R11: ring 16 feeding ring 4
    periodic_pulse_gen #(.PERIOD(64), .MAX_RING(16), .LONG_RING_MAX(0)) dut_e (
        .clk(clk), .rst(rst), .count_en(count_en), .pulse(p_e));

    int per [5] = '{510, 30, 1, 323, 64};
    int cnt [5] = '{0, 0, 0, 0, 0};
    string tag_of [5] = '{"R8", "R6", "R7", "R9", "R11"};

    function automatic bit expect_pulse(bit e, bit r, int c, int p);
        if (r) return 1'b0;
        return e && (c == p - 1);
    endfunction

    task automatic check(string tag, string name, bit got, bit exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0b expected %0b at %0t", tag, name, got, exp, $time);
        end
    endtask

    task automatic step(bit e, bit r, string phase);
        logic got [5];
        @(negedge clk);
        count_en = e;
        rst = r;
        #2;
        got = '{p_a, p_b, p_c, p_d, p_e};
        for (int k = 0; k < 5; k++) begin
            string t;
            if (r) t = "R1";
            else if (!e) t = "R2";
            else if (phase != "") t = phase;
            else t = tag_of[k];
            check(t, $sformatf("dut%0d", k), got[k], expect_pulse(e, r, cnt[k], per[k]));
        end
        @(posedge clk);
        for (int k = 0; k < 5; k++) begin
            if (r) cnt[k] = 0;
            else if (e) cnt[k] = (cnt[k] + 1) % per[k];
        end
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(1234));
        // R1: reset state
        repeat (3) step(1'b0, 1'b1, "");
        // R1: first pulses exactly at PERIOD enables, continuous enable
        for (int i = 0; i < 520; i++) step(1'b1, 1'b0, (i < 510) ? "R1" : "");
        // R4: long idle stretch, then resume
        for (int i = 0; i < 40; i++) step(1'b0, 1'b0, "R4");
        for (int i = 0; i < 300; i++) step(1'b1, 1'b0, "R3");
        // R3: random enables with gaps
        for (int i = 0; i < 3000; i++) step(($urandom % 4) != 0, 1'b0, "");
        // R10: reset mid-period, then count restarts from zero
        repeat (2) step(1'b0, 1'b1, "R10");
        for (int i = 0; i < 700; i++) step(1'b1, 1'b0, "R10");
        // R4: sparse enables
        for (int i = 0; i < 2500; i++) step(($urandom % 5) == 0, 1'b0, "R4");
        // R3: dense random
        for (int i = 0; i < 2000; i++) step(($urandom % 8) != 0, 1'b0, "R3");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule